// File: doc/BRIEF.md
# ROM-to-Ping-Pong Audio Buffer Filler

This block streams 8-bit PCM samples out of a constant on-chip sample ROM and writes them into a two-half (ping-pong) audio sample buffer. A separate playback engine reads that buffer. The block drives only the buffer's write side: address, data and a write strobe. It fills one half of 1024 entries per burst. Then it waits until the playback engine has left the half that comes next, and fills that half.

The ROM contents are generated from the parameters, so no image file is loaded. With the default seed, word k of the ROM holds (k + 1) mod 256. The ROM read pointer runs freely and is kept apart from the buffer address. The sample stream therefore continues without a break from one half to the next, and it wraps at the end of the ROM.

After the first half has been filled, a sticky ready flag tells the playback side that it can start. The very first burst after reset does not look at the consumer's half indicator. Reset is synchronous and active high.

Top module: `rom_pingpong_filler`

## Requirements
- R1: While reset is high, and on the first cycle after it, buf_we is 0, buf_data is 0, buf_addr is 0, ready is 0 and target_half is 0.
- R2: The first burst after reset does not wait on consumer_half, even if it equals target_half. Call E1 the first rising edge at which reset is sampled low. buf_we is still low after E1 and after E2, and goes high after E3 with buf_addr = 0.
- R3: A burst is exactly 1024 consecutive cycles with buf_we high. In those cycles buf_addr rises by exactly one per cycle.
- R4: The n-th sample written since reset (n counted from 0) is ROM word (n mod ROM_DEPTH). With the default parameters that is (n + 1) mod 256, so the write at buffer address i of the first pass carries (i + 1) mod 256.
- R5: In the cycle after the last entry of a half is written, buf_we is 0 and ready is 1.
- R6: target_half names the half being filled or waited for. It toggles in the cycle after the last write of a half: to 1 after the lower half (addresses 0..1023), to 0 after the upper half (addresses 1024..2047).
- R7: After the first burst, no write occurs while consumer_half equals target_half, for as long as that holds.
- R8: Call E1 the first rising edge at which a waiting block samples consumer_half different from target_half. The next burst then shows its first write after E3, at the base address of the target half.
- R9: Every write lands in the half named by target_half. After the upper half, the address wraps from 2047 to 0.
- R10: Once ready is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| consumer_half | input | 1 | Half the playback engine is reading (0 lower, 1 upper) |
| buf_addr | output | 11 | Buffer write address |
| buf_data | output | 8 | Buffer write data (PCM sample) |
| buf_we | output | 1 | Buffer write strobe |
| ready | output | 1 | Sticky flag, set once the first half is full |
| target_half | output | 1 | Half currently being filled or waited for |

## Verification
The assertions assume that consumer_half is a synchronous level, meaning it changes only between clock edges and never in the middle of a burst toward the half being written. The bench changes consumer_half only on falling edges, and only while the block is idle between bursts. It holds each waiting condition for tens to a hundred cycles, which keeps the stimulus inside that assumption. It also assumes that reset is applied before the first clock edge, which the bench does from time zero.

// File: rtl/filler_pkg.sv
package filler_pkg;

  typedef enum logic [1:0] {
    FS_WAIT  = 2'd0,
    FS_RUN   = 2'd1,
    FS_DRAIN = 2'd2
  } fill_state_e;

  // Contents of ROM word k for a given seed and sample width.
  function automatic int rom_word(input int k, input int seed, input int dw);
    return (k + seed) & ((1 << dw) - 1);
  endfunction

  // Free-running ROM pointer step with wrap at the image depth.
  function automatic int next_ptr(input int p, input int depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import filler_pkg::*;
#(
  parameter int HALF_W    = 10,
  parameter int ROM_DEPTH = 256,
  localparam int ROM_AW   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              consumer_half,
  input  logic              half_done,
  output logic              issue,
  output logic [HALF_W:0]   issue_addr,
  output logic [ROM_AW-1:0] rom_ptr,
  output logic              target_half,
  output logic              ready,
  output logic              stall
);

  fill_state_e       state_q, state_d;
  logic [HALF_W-1:0] cnt_q;
  logic [ROM_AW-1:0] ptr_q;
  logic              half_q, ready_q, first_q;
  logic              go, last_issue;

  assign go         = first_q || (consumer_half != half_q);
  assign issue      = (state_q == FS_RUN);
  assign stall      = (state_q == FS_WAIT) && !go;
  assign last_issue = issue && (cnt_q == '1);
  assign issue_addr = {half_q, cnt_q};
  assign rom_ptr    = ptr_q;
  assign target_half = half_q;
  assign ready      = ready_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_WAIT:  if (go) state_d = FS_RUN;
      FS_RUN:   if (last_issue) state_d = FS_DRAIN;
      FS_DRAIN: if (half_done) state_d = FS_WAIT;
      default:  state_d = FS_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_WAIT;
      cnt_q   <= '0;
      ptr_q   <= '0;
      half_q  <= 1'b0;
      ready_q <= 1'b0;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (issue) begin
        cnt_q <= cnt_q + 1'b1;
        ptr_q <= ROM_AW'(next_ptr(int'(ptr_q), ROM_DEPTH));
      end
      if (half_done) begin
        half_q  <= ~half_q;
        ready_q <= 1'b1;
        first_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rom_stage.sv
module rom_stage
  import filler_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ROM_DEPTH = 256,
  parameter int ROM_SEED  = 1,
  localparam int ROM_AW   = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [ROM_AW-1:0] rom_ptr,
  output logic              s1_valid,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [DATA_W-1:0] s1_data
);

  logic [DATA_W-1:0] mem [ROM_DEPTH];

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_word
    assign mem[k] = DATA_W'(rom_word(k, ROM_SEED, DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= issue;
      if (issue) begin
        s1_addr <= issue_addr;
        s1_data <= mem[rom_ptr];
      end
    end
  end

endmodule

// File: rtl/write_stage.sv
module write_stage #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HALF_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [DATA_W-1:0] s1_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              half_done
);

  function automatic logic is_half_end(input logic [ADDR_W-1:0] a);
    return a[HALF_W-1:0] == '1;
  endfunction

  assign half_done = buf_we && is_half_end(buf_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
    end else begin
      buf_we <= s1_valid;
      if (s1_valid) begin
        buf_addr <= s1_addr;
        buf_data <= s1_data;
      end
    end
  end

endmodule

// File: rtl/rom_pingpong_filler.sv
module rom_pingpong_filler #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int ROM_DEPTH = 256,
  parameter int ROM_SEED  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              consumer_half,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_we,
  output logic              ready,
  output logic              target_half
);

  localparam int HALF_W = ADDR_W - 1;
  localparam int ROM_AW = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic              issue, stall, half_done, s1_valid;
  logic [ADDR_W-1:0] issue_addr, s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic [ROM_AW-1:0] rom_ptr;

  fill_ctrl #(.HALF_W(HALF_W), .ROM_DEPTH(ROM_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .consumer_half(consumer_half),
    .half_done(half_done), .issue(issue), .issue_addr(issue_addr),
    .rom_ptr(rom_ptr), .target_half(target_half), .ready(ready),
    .stall(stall)
  );

  rom_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_DEPTH(ROM_DEPTH),
              .ROM_SEED(ROM_SEED)) u_rom (
    .clk(clk), .rst(rst), .issue(issue), .issue_addr(issue_addr),
    .rom_ptr(rom_ptr), .s1_valid(s1_valid), .s1_addr(s1_addr),
    .s1_data(s1_data)
  );

  write_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_addr(s1_addr),
    .s1_data(s1_data), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .half_done(half_done)
  );

endmodule

// File: rtl/filler_checker.sv
module filler_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [DATA_W-1:0] buf_data,
  input logic              buf_we,
  input logic              ready,
  input logic              target_half,
  input logic              half_done,
  input logic              stall,
  input logic              issue
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!buf_we && buf_data == '0 && !ready)); // R1

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |-> (buf_addr == ADDR_W'($past(buf_addr) + 1'b1))); // R3

  AST_DONE_GAP: assert property (@(posedge clk) disable iff (rst)
    half_done |=> (!buf_we && ready)); // R5

  AST_HALF_FLIP: assert property (@(posedge clk) disable iff (rst)
    half_done |=> (target_half != $past(target_half))); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> !issue); // R7

  AST_WRITE_IN_TARGET: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (buf_addr[ADDR_W-1] == target_half)); // R9

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R10

endmodule

bind rom_pingpong_filler filler_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .buf_addr(buf_addr), .buf_data(buf_data),
  .buf_we(buf_we), .ready(ready), .target_half(target_half),
  .half_done(half_done), .stall(stall), .issue(issue)
);

// File: tb/sim_rom_pingpong_filler.sv
`timescale 1ns/1ps
module sim_rom_pingpong_filler;

  localparam int HALF = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        consumer_half = 1'b0;
  logic [10:0] buf_addr;
  logic [7:0]  buf_data;
  logic        buf_we, ready, target_half;

  int n_checks = 0;
  int n_err    = 0;
  int beat_n   = 0;
  bit reported = 1'b0;
  int qa[$];
  int qd[$];

  rom_pingpong_filler u0 (
    .clk(clk), .rst(rst), .consumer_half(consumer_half),
    .buf_addr(buf_addr), .buf_data(buf_data), .buf_we(buf_we),
    .ready(ready), .target_half(target_half)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Driver: expected writes of one half, data from the running sample count.
  task automatic push_half(input int half);
    for (int j = 0; j < HALF; j++) begin
      qa.push_back(half * HALF + j);
      qd.push_back((beat_n + 1) % 256);
      beat_n++;
    end
  endtask

  // Monitor: every observed write is compared against the scoreboard.
  always @(negedge clk) begin
    if (!rst && buf_we) begin
      if (qa.size() == 0) begin
        chk(1'b0, "R3 unexpected write", int'(buf_addr), -1);
      end else begin
        int ea, ed;
        ea = qa.pop_front();
        ed = qd.pop_front();
        chk(int'(buf_addr) == ea, "R9 write address", int'(buf_addr), ea);
        chk(int'(buf_data) == ed, "R4 write data", int'(buf_data), ed);
      end
    end
  end

  task automatic check_start(input string req, input int base);
    step();
    chk(buf_we == 1'b0, {req, " no write after E1"}, int'(buf_we), 0);
    step();
    chk(buf_we == 1'b0, {req, " no write after E2"}, int'(buf_we), 0);
    step();
    chk(buf_we == 1'b1, {req, " write after E3"}, int'(buf_we), 1);
    chk(int'(buf_addr) == base, {req, " first address"}, int'(buf_addr), base);
  endtask

  task automatic count_burst();
    int beats;
    beats = 1;
    while (buf_we) begin
      step();
      if (buf_we) beats++;
    end
    chk(beats == HALF, "R3 burst length", beats, HALF);
  endtask

  task automatic hold_stall(input int cycles);
    int seen;
    seen = 0;
    for (int c = 0; c < cycles; c++) begin
      step();
      if (buf_we) seen++;
    end
    chk(seen == 0, "R7 writes while stalled", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk(buf_we == 1'b0, "R1 we in reset", int'(buf_we), 0);
    chk(buf_data == 8'd0, "R1 data in reset", int'(buf_data), 0);
    chk(buf_addr == 11'd0, "R1 addr in reset", int'(buf_addr), 0);
    chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
    chk(target_half == 1'b0, "R1 half in reset", int'(target_half), 0);

    // R2 first fill ignores consumer_half (held equal to target 0)
    push_half(0);
    rst = 1'b0;
    check_start("R2", 0);
    count_burst();
    chk(ready == 1'b1, "R5 ready after first half", int'(ready), 1);
    chk(buf_we == 1'b0, "R5 we low after half", int'(buf_we), 0);
    chk(target_half == 1'b1, "R6 half after lower", int'(target_half), 1);

    // R7 consumer occupies the upper half
    consumer_half = 1'b1;
    hold_stall(100);
    chk(ready == 1'b1, "R10 ready during stall", int'(ready), 1);

    // R8 resume into the upper half
    push_half(1);
    consumer_half = 1'b0;
    check_start("R8", HALF);
    count_burst();
    chk(ready == 1'b1, "R10 ready after second half", int'(ready), 1);
    chk(target_half == 1'b0, "R6 half after upper", int'(target_half), 0);

    // Consumer still on lower half: stalled again
    hold_stall(20);

    // R9 wrap back to address 0, sample stream continues
    push_half(0);
    consumer_half = 1'b1;
    check_start("R9", 0);
    count_burst();
    chk(target_half == 1'b1, "R6 half after third fill", int'(target_half), 1);
    chk(qa.size() == 0, "R4 all expected samples written", qa.size(), 0);

    report();
    $finish;
  end

endmodule